// File: doc/BRIEF.md
# Function-Independent Test Sequencer

This block runs a fixed self-test of a programmable AND-OR array. The array has been extended for testability. Each of its AND columns is gated by one stage of a serial shift register, and one extra parity column makes every AND row carry an odd number of connections. An extra OR row makes every OR column carry an odd number of connections. Two parity outputs come back from the array: Z1 is the XOR of the gated column outputs, and Z2 is the XOR of the OR rows. The input decoders take two control lines. AND row 2i-1 carries `x_i | y1`, and AND row 2i carries `~x_i | y2`.

After a start pulse, the sequencer applies a list of 2N+3M patterns, where N is the number of inputs and M the number of original columns. The patterns and their expected parity answers depend only on N and M, so the same sequencer tests any programmed function of that size. For each pattern the block shifts the column-enable word into the array's M+1-stage register. It then holds the pattern for one settle cycle and compares Z1 and Z2 at the end of that cycle. Any expected bit that is a don't-care is masked out. The first mismatch is latched together with its pattern index. When the list ends, the block reports done and pass.

States: IDLE (waits for start), LOAD (shifts M+1 column bits), SETTLE (holds the pattern, samples Z1/Z2), DONE (holds the verdict). Transitions: IDLE→LOAD and DONE→LOAD on start; LOAD→SETTLE after the (M+1)th shift; SETTLE→LOAD if patterns remain; SETTLE→DONE after the last pattern.

Top module: `tsq_top`

## Requirements
- R1: While reset is held and just after it, done, pass, fail, sr_shift and sr_din are 0, fail_idx is 0, and pla_x, pla_y1 and pla_y2 are 0.
- R2: A run applies L = 2N+3M patterns, index 0 to L-1, in this order: index 0 is the blank pattern; 1..M are select-low for columns 1..M; M+1..2M are select-high for columns 1..M; 2M+1..3M-1 are walk patterns for i = 1..M-1; 3M..3M+N-1 are odd-row force patterns for i = 1..N; 3M+N..3M+2N-1 are even-row force patterns for i = 1..N.
- R3: Each pattern takes M+1 cycles with sr_shift high, then one settle cycle with sr_shift low. Column bits go out on sr_din starting with column M+1 and ending with column 1, so that after the load, register stage k (stage 1 takes sr_din) holds column k's enable. pla_x and pla_y hold their values through load and settle. done rises L·(M+2) cycles after the clock edge that accepts start.
- R4: A select pattern drives pla_x all 0 (select-low) or all 1 (select-high), with y1=y2=1, and enables only column j. The expected values are Z1=1 and Z2=1.
- R5: The blank pattern drives pla_x=0 and y1=y2=1 with no column enabled. The expected values are Z1=0 and Z2=0.
- R6: Walk pattern i drives pla_x=0 and y1=y2=1, and enables columns 1..i. The expected Z1 is i mod 2. Z2 is not compared.
- R7: Force pattern i enables all M+1 columns. The odd-row form drives pla_x all 1 except bit i-1 at 0, with y1=0 and y2=1. The even-row form drives only bit i-1 of pla_x at 1, with y1=1 and y2=0. The expected Z1 is 1 when M is odd and 0 when M is even. Z2 is not compared.
- R8: Z1 and Z2 are sampled at the clock edge that ends the settle cycle. Z2 has no effect on the verdict during walk and force patterns.
- R9: The first pattern whose compared bits mismatch sets fail and loads its index into fail_idx. Later mismatches change neither output. The run always continues to the last pattern.
- R10: done is high from the end of the last pattern until the next accepted start. pass equals done and not fail.
- R11: start is accepted only in IDLE or DONE, and acceptance clears fail and fail_idx. A start pulse during a run has no effect on the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| z1 | input | 1 | Column-parity output of the array |
| z2 | input | 1 | Row-parity output of the array |
| pla_x | output | N_IN | Primary inputs to the array decoders; bit i-1 is input i |
| pla_y1 | output | 1 | Decoder control for odd AND rows |
| pla_y2 | output | 1 | Decoder control for even AND rows |
| sr_din | output | 1 | Serial data into column-enable register stage 1 |
| sr_shift | output | 1 | Shift enable for the column-enable register |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | A mismatch has been seen in this run |
| fail_idx | output | clog2(2N+3M) | Index of the first mismatching pattern |

## Verification
A pattern counter or load counter that slips shows at the array pins within the same pattern: the enable word that lands in the register is wrong, or the shift count is not M+1. The bench catches both at every settle cycle with a model of the array and its register. A wrong expected value or a broken mask shows as a wrong fail flag or fail index at done. Injected array faults and faults on the parity lines each have a first-failing pattern that the requirements fix in advance. A state machine that misbehaves around start or the final pattern shifts the time at which done rises, which the bench measures to the cycle.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETTLE,
        ST_DONE
    } tsq_state_e;

    typedef enum logic [2:0] {
        PK_BLANK,
        PK_SEL_LO,
        PK_SEL_HI,
        PK_WALK,
        PK_FORCE_ODD,
        PK_FORCE_EVEN
    } tsq_kind_e;
endpackage

// File: rtl/tsq_counter.sv
module tsq_counter #(
    parameter int W     = 4,
    parameter int LIMIT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         at_limit
);
    always_ff @(posedge clk) begin
        if (!rst_n)   val <= '0;
        else if (clr) val <= '0;
        else if (inc) val <= val + 1'b1;
    end

    assign at_limit = (val == W'(LIMIT));
endmodule

// File: rtl/tsq_pattern_decode.sv
module tsq_pattern_decode
    import tsq_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int M_COL = 4,
    parameter int IW    = 5,
    parameter int CW    = 3
) (
    input  logic [IW-1:0]   pat,
    input  logic [CW-1:0]   col,
    output logic [N_IN-1:0] x,
    output logic            y1,
    output logic            y2,
    output logic            col_on,
    output logic            exp_z1,
    output logic            exp_z2,
    output logic            chk_z2
);
    localparam logic FORCE_Z1 = logic'(M_COL % 2);

    always_comb begin
        int p;
        int c;
        int s;
        tsq_kind_e kind;
        p = int'(pat);
        c = int'(col);
        if (p == 0) begin
            kind = PK_BLANK;      s = 0;
        end else if (p <= M_COL) begin
            kind = PK_SEL_LO;     s = p;
        end else if (p <= 2*M_COL) begin
            kind = PK_SEL_HI;     s = p - M_COL;
        end else if (p < 3*M_COL) begin
            kind = PK_WALK;       s = p - 2*M_COL;
        end else if (p < 3*M_COL + N_IN) begin
            kind = PK_FORCE_ODD;  s = p - 3*M_COL + 1;
        end else begin
            kind = PK_FORCE_EVEN; s = p - 3*M_COL - N_IN + 1;
        end

        x      = '0;
        y1     = 1'b1;
        y2     = 1'b1;
        col_on = 1'b0;
        exp_z1 = 1'b0;
        exp_z2 = 1'b0;
        chk_z2 = 1'b1;
        unique case (kind)
            PK_BLANK: ;
            PK_SEL_LO: begin
                col_on = (c == s);
                exp_z1 = 1'b1;
                exp_z2 = 1'b1;
            end
            PK_SEL_HI: begin
                x      = '1;
                col_on = (c == s);
                exp_z1 = 1'b1;
                exp_z2 = 1'b1;
            end
            PK_WALK: begin
                col_on = (c <= s);
                exp_z1 = logic'(s % 2);
                chk_z2 = 1'b0;
            end
            PK_FORCE_ODD: begin
                for (int b = 0; b < N_IN; b++) x[b] = (b != s - 1);
                y1     = 1'b0;
                col_on = 1'b1;
                exp_z1 = FORCE_Z1;
                chk_z2 = 1'b0;
            end
            PK_FORCE_EVEN: begin
                for (int b = 0; b < N_IN; b++) x[b] = (b == s - 1);
                y2     = 1'b0;
                col_on = 1'b1;
                exp_z1 = FORCE_Z1;
                chk_z2 = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tsq_result.sv
module tsq_result #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic [IW-1:0] pat,
    input  logic          z1,
    input  logic          z2,
    input  logic          exp_z1,
    input  logic          exp_z2,
    input  logic          chk_z2,
    output logic          fail,
    output logic [IW-1:0] fail_idx
);
    logic mismatch;

    assign mismatch = (z1 != exp_z1) | (chk_z2 & (z2 != exp_z2));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail     <= 1'b0;
            fail_idx <= '0;
        end else if (sample && mismatch && !fail) begin
            fail     <= 1'b1;
            fail_idx <= pat;
        end
    end

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> (fail && $stable(fail_idx)));

    // R8
    fail_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(sample));
endmodule

// File: rtl/tsq_top.sv
module tsq_top
    import tsq_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int M_COL = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic                                 z1,
    input  logic                                 z2,
    output logic [N_IN-1:0]                      pla_x,
    output logic                                 pla_y1,
    output logic                                 pla_y2,
    output logic                                 sr_din,
    output logic                                 sr_shift,
    output logic                                 done,
    output logic                                 pass,
    output logic                                 fail,
    output logic [$clog2(2*N_IN+3*M_COL)-1:0]    fail_idx
);
    localparam int NPAT = 2*N_IN + 3*M_COL;
    localparam int IW   = $clog2(NPAT);
    localparam int CW   = $clog2(M_COL + 2);

    tsq_state_e state, state_nx;

    logic [IW-1:0]   pat_idx;
    logic [CW-1:0]   bit_cnt;
    logic [CW-1:0]   col;
    logic            pat_last, bit_last, accept;
    logic [N_IN-1:0] dec_x;
    logic            dec_y1, dec_y2, dec_col_on;
    logic            exp_z1, exp_z2, chk_z2;

    assign accept = start && (state == ST_IDLE || state == ST_DONE);
    assign col    = CW'(M_COL + 1) - bit_cnt;

    tsq_counter #(.W(IW), .LIMIT(NPAT - 1)) u_pat_ctr (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .inc(state == ST_SETTLE && !pat_last),
        .val(pat_idx), .at_limit(pat_last)
    );

    tsq_counter #(.W(CW), .LIMIT(M_COL)) u_bit_ctr (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_LOAD),
        .inc(state == ST_LOAD),
        .val(bit_cnt), .at_limit(bit_last)
    );

    tsq_pattern_decode #(.N_IN(N_IN), .M_COL(M_COL), .IW(IW), .CW(CW)) u_dec (
        .pat(pat_idx), .col(col), .x(dec_x), .y1(dec_y1), .y2(dec_y2),
        .col_on(dec_col_on), .exp_z1(exp_z1), .exp_z2(exp_z2), .chk_z2(chk_z2)
    );

    tsq_result #(.IW(IW)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(accept), .sample(state == ST_SETTLE),
        .pat(pat_idx), .z1(z1), .z2(z2), .exp_z1(exp_z1), .exp_z2(exp_z2),
        .chk_z2(chk_z2), .fail(fail), .fail_idx(fail_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)    state_nx = ST_LOAD;
            ST_LOAD:   if (bit_last) state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = pat_last ? ST_DONE : ST_LOAD;
            ST_DONE:   if (start)    state_nx = ST_LOAD;
        endcase
    end

    always_comb begin
        logic active;
        active   = (state == ST_LOAD) || (state == ST_SETTLE);
        pla_x    = active ? dec_x  : '0;
        pla_y1   = active ? dec_y1 : 1'b0;
        pla_y2   = active ? dec_y2 : 1'b0;
        sr_shift = (state == ST_LOAD);
        sr_din   = sr_shift & dec_col_on;
        done     = (state == ST_DONE);
        pass     = done & ~fail;
    end

    // R3
    load_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_shift && bit_last) |=> !sr_shift);

    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_shift && start) |=> !done);

    // R10
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R2
    pat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_idx <= IW'(NPAT - 1));
endmodule

// File: tb/tsq_top_tb.sv
module tsq_top_tb;
    localparam int CLK_P = 10;
    localparam int N     = 3;
    localparam int M     = 4;
    localparam int L     = 2*N + 3*M;
    localparam int C     = M + 1;
    localparam int R     = 2*N;
    localparam int OR_N  = 3;
    localparam int IW    = $clog2(L);

    logic clk = 1'b0;
    logic rst_n, start;
    logic z1, z2;
    logic [N-1:0] pla_x;
    logic pla_y1, pla_y2, sr_din, sr_shift, done, pass, fail;
    logic [IW-1:0] fail_idx;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    tsq_top #(.N_IN(N), .M_COL(M)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .z1(z1), .z2(z2),
        .pla_x(pla_x), .pla_y1(pla_y1), .pla_y2(pla_y2),
        .sr_din(sr_din), .sr_shift(sr_shift), .done(done), .pass(pass),
        .fail(fail), .fail_idx(fail_idx)
    );

    // model of the augmented array
    logic [C-1:0]    and_cx [R];
    logic [C-1:0]    or_cx  [OR_N];
    logic [C:1]      sr;
    int              z1_mode = 0;
    int              z2_mode = 0;
    bit              and_flip = 0;
    bit              or_flip  = 0;
    int              kb;
    bit              kb_clr = 0;
    logic            shift_d;
    int              sh_cnt;

    always @(posedge clk) begin
        if (sr_shift) sr <= {sr[C-1:1], sr_din};
    end

    always @(posedge clk) begin
        if (kb_clr) kb <= 0;
        else if (!sr_shift && shift_d) kb <= kb + 1;
        shift_d <= sr_shift;
        if (sr_shift) sh_cnt <= sh_cnt + 1;
        else          sh_cnt <= 0;
    end

    always_comb begin
        logic [R-1:0]    rv;
        logic [C-1:0]    b;
        logic [OR_N-1:0] ov;
        logic            a1, cz1, cz2, ae, oe;
        for (int i = 0; i < N; i++) begin
            rv[2*i]   = pla_x[i] | pla_y1;
            rv[2*i+1] = ~pla_x[i] | pla_y2;
        end
        for (int c = 0; c < C; c++) begin
            a1 = 1'b1;
            for (int r = 0; r < R; r++) begin
                ae = and_cx[r][c] ^ (and_flip && r == 3 && c == 0);
                if (ae) a1 = a1 & rv[r];
            end
            b[c] = a1 & sr[c+1];
        end
        for (int k = 0; k < OR_N; k++) begin
            ov[k] = 1'b0;
            for (int c = 0; c < C; c++) begin
                oe = or_cx[k][c] ^ (or_flip && k == 0 && c == 2);
                if (oe) ov[k] = ov[k] | b[c];
            end
        end
        cz1 = ^b;
        cz2 = ^ov;
        case (z1_mode)
            1:       z1 = 1'b1;
            2:       z1 = (kb >= 2*M+1 && kb < 3*M) ? ~cz1 : cz1;
            3:       z1 = (kb >= 3*M) ? ~cz1 : cz1;
            default: z1 = cz1;
        endcase
        case (z2_mode)
            1:       z2 = 1'b0;
            2:       z2 = (kb >= 2*M+1) ? ~cz2 : cz2;
            default: z2 = cz2;
        endcase
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N+2+C-1:0] exp_drive(input int k);
        logic [N-1:0] x;
        logic y1, y2;
        logic [C:1] cols;
        x = '0; y1 = 1'b1; y2 = 1'b1; cols = '0;
        if (k == 0) begin
        end else if (k <= M) begin
            cols[k] = 1'b1;
        end else if (k <= 2*M) begin
            x = '1; cols[k-M] = 1'b1;
        end else if (k < 3*M) begin
            for (int q = 1; q <= k - 2*M; q++) cols[q] = 1'b1;
        end else if (k < 3*M + N) begin
            x = '1; x[k-3*M] = 1'b0; y1 = 1'b0; cols = '1;
        end else begin
            x[k-3*M-N] = 1'b1; y2 = 1'b0; cols = '1;
        end
        return {x, y1, y2, cols};
    endfunction

    function automatic string req_of(input int k);
        if (k == 0) return "R5";
        if (k <= 2*M) return "R4";
        if (k < 3*M) return "R6";
        return "R7";
    endfunction

    // per-pattern drive check at the settle cycle
    always @(negedge clk) begin
        if (rst_n && !sr_shift && shift_d) begin
            check(sh_cnt == C, "R3 shift count", 32'(sh_cnt), 32'(C));
            check({pla_x, pla_y1, pla_y2, sr} == exp_drive(kb),
                  {req_of(kb), " R2 pattern drive"},
                  32'({pla_x, pla_y1, pla_y2, sr}), 32'(exp_drive(kb)));
        end
    end

    task automatic run_seq(input int m1, input int m2, input bit af, input bit of,
                           input bit midstart, input bit exp_pass, input int exp_idx,
                           input string req);
        int cyc;
        @(negedge clk);
        z1_mode = m1; z2_mode = m2; and_flip = af; or_flip = of;
        kb_clr = 1;
        @(negedge clk);
        kb_clr = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            start = (midstart && cyc == 20);
            @(negedge clk);
            cyc++;
        end
        start = 0;
        check(cyc == L*(M+2), "R3 R11 done timing", 32'(cyc), 32'(L*(M+2)));
        check(kb == L, "R2 pattern count", 32'(kb), 32'(L));
        check(pass == exp_pass, {req, " R10 pass"}, 32'(pass), 32'(exp_pass));
        check(fail == !exp_pass, {req, " R9 fail"}, 32'(fail), 32'(!exp_pass));
        check(int'(fail_idx) == exp_idx, {req, " R9 fail_idx"}, 32'(fail_idx), 32'(exp_idx));
    endtask

    initial begin
        #(CLK_P*200000);
        nfail++;
        $display("FAIL R10 watchdog act=running exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int cnt;
        for (int r = 0; r < R; r++) begin
            cnt = 0;
            for (int c = 0; c < M; c++) begin
                and_cx[r][c] = ((r + 2*c + 1) % 3 == 0);
                cnt += int'(and_cx[r][c]);
            end
            and_cx[r][M] = (cnt % 2 == 0);
        end
        for (int c = 0; c < C; c++) begin
            or_cx[0][c] = (c % 2 == 0);
            or_cx[1][c] = (c % 3 != 1);
            or_cx[2][c] = ~(or_cx[0][c] ^ or_cx[1][c]);
        end
        sr = '0;
        start = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check({done, pass, fail, sr_shift, sr_din} == 5'b0, "R1 reset flags",
              32'({done, pass, fail, sr_shift, sr_din}), 32'h0);
        check({pla_x, pla_y1, pla_y2, fail_idx} == '0, "R1 reset drive",
              32'({pla_x, pla_y1, pla_y2, fail_idx}), 32'h0);
        rst_n = 1;
        @(negedge clk);
        check(!done && !sr_shift, "R1 idle after reset", 32'({done, sr_shift}), 32'h0);

        run_seq(0, 0, 0, 0, 0, 1, 0, "R10 clean");
        run_seq(1, 0, 0, 0, 0, 0, 0, "R9 z1 stuck1");
        run_seq(0, 0, 0, 0, 0, 1, 0, "R11 restart clears");
        run_seq(0, 1, 0, 0, 0, 0, 1, "R4 z2 stuck0");
        run_seq(0, 0, 1, 0, 0, 0, 3*M + N + 1, "R7 and crosspoint");
        run_seq(0, 0, 0, 1, 0, 0, 3, "R4 or crosspoint");
        run_seq(2, 0, 0, 0, 0, 0, 2*M + 1, "R6 walk z1");
        run_seq(3, 0, 0, 0, 0, 0, 3*M, "R7 force z1");
        run_seq(0, 2, 0, 0, 0, 1, 0, "R8 z2 masked");
        run_seq(0, 0, 0, 0, 1, 1, 0, "R11 busy start");

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule